// File: doc/BRIEF.md
# Split PCM Sample Reassembler

This block rebuilds multichannel linear PCM samples from a packed 16-bit word stream. Samples arrive in pairs of sample periods (an even period followed by an odd one) for one to eight channels. At 16-bit resolution each sample is a single word. At 20-bit or 24-bit resolution each sample is cut in two. The 16-bit upper parts of all channels come first, even period before odd, and are followed by a group of words that carry the 4-bit or 8-bit lower parts of every sample. The block collects one complete pair and then emits the samples one at a time with a channel index.

Each emitted sample has two views. The converter view is a 24-bit sample aligned to the most significant bit, at the resolution in force. The digital-interface view is the 16-bit upper part only. A host override can replace the stream resolution on the converter view with a programmed one. A narrower setting truncates the sample and a wider setting pads it with zeros. Stream resolution, channel count and override are captured with the first word of each pair.

Top module: `pcm_split_reasm`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A pair holds 2N upper words, where N = `cfg_nch`+1. Word k of the pair is the upper part of channel k mod N, for the even period when k < N and the odd period otherwise. Samples leave in the same order, with `out_ch` = channel and `out_odd` = period.
- R3: At 20-bit resolution (`cfg_res` = 1) the lower group holds 4 bits per sample in sample order, the first sample in the most significant nibble of the first lower word. It is zero padded to ceil(8N/16) words, and `out_dac` = {upper, nibble, 4'b0}.
- R4: At 24-bit resolution (`cfg_res` = 2) the lower group holds 8 bits per sample in the same order (N words), and `out_dac` = {upper, byte}.
- R5: `out_spdif` always equals the upper 16 bits of the sample, whatever the resolution or override.
- R6: With `ovr_en` = 1 and `ovr_res` narrower than the stream, `out_dac` keeps only the top 16 (code 0) or 20 (code 1) bits and clears the rest.
- R7: With `ovr_en` = 1 and `ovr_res` wider than the stream, the sample is extended with zero bits at the least significant end.
- R8: The block either accepts input or presents output, never both in one cycle. A presented sample that is not accepted holds all output fields stable.
- R9: Resolution, channel count and override are sampled with the first word of a pair. Later changes within that pair do not affect its word count or its samples.
- R10: Channel counts 1 to 8 are supported, and `out_ch` never exceeds `cfg_nch` as captured. Resolution code 3 is treated as 16-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts a word |
| in_data | input | 16 | Payload word |
| cfg_res | input | 2 | Stream resolution: 0=16, 1=20, 2=24, 3=16 |
| cfg_nch | input | 3 | Channel count minus one |
| ovr_en | input | 1 | Host override enable for output resolution |
| ovr_res | input | 2 | Override resolution, same coding as cfg_res |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Sink takes the sample |
| out_dac | output | 24 | Converter sample, MSB aligned |
| out_spdif | output | 16 | 16-bit sample for the digital interface |
| out_ch | output | 3 | Channel index |
| out_odd | output | 1 | 0 = even period, 1 = odd period |

## Verification
Two events can land in the same cycle. One is the acceptance of the final sample of a pair. The other is the arrival of the first word of the next pair, which the source already holds valid. The bench keeps the source always pending while the sink stalls at random. It judges that `in_ready` stays low until the cycle after the last sample leaves, and that the next pair's samples still match the scoreboard. A second overlap comes from changing the configuration in the cycle after the first word is accepted. The expected word count and samples must follow the captured values, not the new ones.

// File: rtl/pcm_reasm_pkg.sv
package pcm_reasm_pkg;

  typedef enum logic [1:0] {
    RES_16  = 2'd0,
    RES_20  = 2'd1,
    RES_24  = 2'd2,
    RES_RSV = 2'd3
  } res_e;

  // Reserved code folds onto 16-bit.
  function automatic res_e norm_res(input logic [1:0] code);
    case (code)
      2'd1:    return RES_20;
      2'd2:    return RES_24;
      default: return RES_16;
    endcase
  endfunction

  // Lower-part bits carried per sample.
  function automatic int unsigned low_width(input res_e r);
    case (r)
      RES_20:  return 4;
      RES_24:  return 8;
      default: return 0;
    endcase
  endfunction

  // Words in one pair of periods for a channel count.
  function automatic int unsigned pair_word_count(input int unsigned chans, input res_e r);
    return 2 * chans + (2 * chans * low_width(r) + 15) / 16;
  endfunction

  // Joins an upper word with its lower chunk (chunk left aligned).
  function automatic logic [23:0] merge_parts(input logic [15:0] up, input logic [7:0] chunk,
                                              input res_e r);
    case (r)
      RES_20:  return {up, chunk[7:4], 4'h0};
      RES_24:  return {up, chunk};
      default: return {up, 8'h00};
    endcase
  endfunction

  // Trims a sample to an output resolution; wider settings keep the zeros.
  function automatic logic [23:0] fit_width(input logic [23:0] s, input res_e r);
    case (r)
      RES_20:  return {s[23:4], 4'h0};
      RES_24:  return s;
      default: return {s[23:8], 8'h00};
    endcase
  endfunction

endpackage

// File: rtl/pcm_pair_store.sv
module pcm_pair_store
  import pcm_reasm_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CH_W   = 3,
  localparam int UP_SLOTS = 2 * MAX_CH,
  localparam int LO_SLOTS = MAX_CH,
  localparam int SLOT_W   = $clog2(UP_SLOTS + LO_SLOTS + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           accept_en,
  input  logic                           in_valid,
  input  logic [15:0]                    in_data,
  input  logic [1:0]                     cfg_res,
  input  logic [CH_W-1:0]                cfg_nch,
  input  logic                           ovr_en,
  input  logic [1:0]                     ovr_res,
  output logic                           accept,
  output logic                           pair_last,
  output logic [UP_SLOTS-1:0][15:0]      up_mem,
  output logic [LO_SLOTS-1:0][15:0]      lo_mem,
  output res_e                           res_q,
  output res_e                           ores_q,
  output logic [CH_W-1:0]                nch_q
);

  logic [SLOT_W-1:0] wcnt;
  logic              first_word;
  res_e              eff_res;
  logic [CH_W-1:0]   eff_nch;
  logic [SLOT_W-1:0] up_lim;
  logic [SLOT_W-1:0] last_idx;

  assign first_word = (wcnt == '0);
  assign eff_res    = first_word ? norm_res(cfg_res) : res_q;
  assign eff_nch    = first_word ? cfg_nch : nch_q;

  always_comb begin
    up_lim   = SLOT_W'(2 * (int'(eff_nch) + 1));
    last_idx = SLOT_W'(pair_word_count(int'(eff_nch) + 1, eff_res) - 1);
  end

  assign accept    = in_valid && accept_en;
  assign pair_last = accept && (wcnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      res_q  <= RES_16;
      ores_q <= RES_16;
      nch_q  <= '0;
    end else if (accept) begin
      if (first_word) begin
        res_q  <= norm_res(cfg_res);
        nch_q  <= cfg_nch;
        ores_q <= ovr_en ? norm_res(ovr_res) : norm_res(cfg_res);
      end
      wcnt <= pair_last ? '0 : wcnt + 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < UP_SLOTS; gi++) begin : g_up
      always_ff @(posedge clk) begin
        if (accept && (wcnt == SLOT_W'(gi)))
          up_mem[gi] <= in_data;
      end
    end
    for (gi = 0; gi < LO_SLOTS; gi++) begin : g_lo
      always_ff @(posedge clk) begin
        if (accept && (wcnt >= up_lim) && ((wcnt - up_lim) == SLOT_W'(gi)))
          lo_mem[gi] <= in_data;
      end
    end
  endgenerate

endmodule

// File: rtl/pcm_emit_ctrl.sv
module pcm_emit_ctrl #(
  parameter int MAX_CH = 8,
  parameter int CH_W   = 3,
  localparam int IDX_W = $clog2(2 * MAX_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_last,
  input  logic             out_ready,
  input  logic [CH_W-1:0]  nch_q,
  output logic             collect,
  output logic             out_valid,
  output logic [IDX_W-1:0] idx,
  output logic [CH_W-1:0]  ch,
  output logic             odd,
  output logic             fire,
  output logic             last_fire
);

  typedef enum logic {ST_FILL, ST_DRAIN} st_e;
  st_e st;

  assign collect   = (st == ST_FILL);
  assign out_valid = (st == ST_DRAIN);
  assign fire      = out_valid && out_ready;
  assign last_fire = fire && odd && (ch == nch_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_FILL;
      idx <= '0;
      ch  <= '0;
      odd <= 1'b0;
    end else begin
      case (st)
        ST_FILL: begin
          if (pair_last) begin
            st  <= ST_DRAIN;
            idx <= '0;
            ch  <= '0;
            odd <= 1'b0;
          end
        end
        default: begin
          if (last_fire) begin
            st <= ST_FILL;
          end else if (fire) begin
            idx <= idx + 1'b1;
            if (ch == nch_q) begin
              ch  <= '0;
              odd <= 1'b1;
            end else begin
              ch <= ch + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pcm_sample_pick.sv
module pcm_sample_pick
  import pcm_reasm_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int UP_SLOTS = 2 * MAX_CH,
  localparam int LO_SLOTS = MAX_CH,
  localparam int LO_BITS  = 16 * LO_SLOTS,
  localparam int IDX_W    = $clog2(2 * MAX_CH),
  localparam int SH_W     = $clog2(LO_BITS)
) (
  input  logic [UP_SLOTS-1:0][15:0] up_mem,
  input  logic [LO_SLOTS-1:0][15:0] lo_mem,
  input  logic [IDX_W-1:0]          idx,
  input  res_e                      res_q,
  input  res_e                      ores_q,
  output logic [23:0]               dac,
  output logic [15:0]               spdif
);

  logic [LO_BITS-1:0] lovec;
  logic [LO_BITS-1:0] shifted;
  logic [SH_W-1:0]    shamt;
  logic [7:0]         chunk;
  logic [15:0]        upper;

  // First lower word sits at the most significant end.
  genvar gi;
  generate
    for (gi = 0; gi < LO_SLOTS; gi++) begin : g_cat
      assign lovec[(LO_SLOTS-1-gi)*16 +: 16] = lo_mem[gi];
    end
  endgenerate

  always_comb begin
    shamt   = SH_W'(int'(idx) * int'(low_width(res_q)));
    shifted = lovec << shamt;
    chunk   = shifted[LO_BITS-1 -: 8];
    upper   = up_mem[idx];
    dac     = fit_width(merge_parts(upper, chunk, res_q), ores_q);
    spdif   = upper;
  end

endmodule

// File: rtl/pcm_split_reasm.sv
module pcm_split_reasm
  import pcm_reasm_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_data,
  input  logic [1:0]      cfg_res,
  input  logic [CH_W-1:0] cfg_nch,
  input  logic            ovr_en,
  input  logic [1:0]      ovr_res,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [23:0]     out_dac,
  output logic [15:0]     out_spdif,
  output logic [CH_W-1:0] out_ch,
  output logic            out_odd
);

  localparam int UP_SLOTS = 2 * MAX_CH;
  localparam int LO_SLOTS = MAX_CH;
  localparam int IDX_W    = $clog2(2 * MAX_CH);

  // Named internal events, observed by the bound checker.
  logic                      w_collect;
  logic                      w_accept;
  logic                      w_pair_last;
  logic                      w_out_fire;
  logic                      w_emit_last;
  logic [CH_W-1:0]           w_nch_q;
  res_e                      w_res_q;
  res_e                      w_res_out;
  logic [IDX_W-1:0]          w_idx;
  logic [UP_SLOTS-1:0][15:0] w_up_mem;
  logic [LO_SLOTS-1:0][15:0] w_lo_mem;

  pcm_pair_store #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .accept_en (w_collect),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cfg_res   (cfg_res),
    .cfg_nch   (cfg_nch),
    .ovr_en    (ovr_en),
    .ovr_res   (ovr_res),
    .accept    (w_accept),
    .pair_last (w_pair_last),
    .up_mem    (w_up_mem),
    .lo_mem    (w_lo_mem),
    .res_q     (w_res_q),
    .ores_q    (w_res_out),
    .nch_q     (w_nch_q)
  );

  pcm_emit_ctrl #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pair_last (w_pair_last),
    .out_ready (out_ready),
    .nch_q     (w_nch_q),
    .collect   (w_collect),
    .out_valid (out_valid),
    .idx       (w_idx),
    .ch        (out_ch),
    .odd       (out_odd),
    .fire      (w_out_fire),
    .last_fire (w_emit_last)
  );

  pcm_sample_pick #(.MAX_CH(MAX_CH)) u_pick (
    .up_mem (w_up_mem),
    .lo_mem (w_lo_mem),
    .idx    (w_idx),
    .res_q  (w_res_q),
    .ores_q (w_res_out),
    .dac    (out_dac),
    .spdif  (out_spdif)
  );

  assign in_ready = w_collect;

endmodule

// File: rtl/pcm_split_reasm_chk.sv
module pcm_split_reasm_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [23:0]     out_dac,
  input logic [15:0]     out_spdif,
  input logic [CH_W-1:0] out_ch,
  input logic            out_odd,
  input logic            pair_last,
  input logic            emit_last,
  input logic [CH_W-1:0] nch_q,
  input logic [1:0]      res_out
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  a_r8_one_side: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_dac) && $stable(out_spdif) && $stable(out_ch) && $stable(out_odd)));

  a_r5_spdif_upper: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_spdif == out_dac[23:8]));

  a_r6_trim_16: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_out == 2'd0) |-> (out_dac[7:0] == 8'h00));

  a_r6_trim_20: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_out == 2'd1) |-> (out_dac[3:0] == 4'h0));

  a_r2_drain_start: assert property (@(posedge clk) disable iff (rst)
    pair_last |=> (out_valid && out_ch == '0 && !out_odd));

  a_r2_drain_end: assert property (@(posedge clk) disable iff (rst)
    emit_last |=> (in_ready && !out_valid));

  a_r10_ch_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ch <= nch_q));

endmodule

bind pcm_split_reasm pcm_split_reasm_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dac   (out_dac),
  .out_spdif (out_spdif),
  .out_ch    (out_ch),
  .out_odd   (out_odd),
  .pair_last (w_pair_last),
  .emit_last (w_emit_last),
  .nch_q     (w_nch_q),
  .res_out   (w_res_out)
);

// File: tb/pcm_split_reasm_test.sv
module pcm_split_reasm_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [1:0]  cfg_res = '0;
  logic [2:0]  cfg_nch = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_res = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_dac;
  logic [15:0] out_spdif;
  logic [2:0]  out_ch;
  logic        out_odd;

  int n_checks = 0;
  int n_fail = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [23:0] dac;
    logic [15:0] spdif;
    int          ch;
    bit          odd;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  pcm_split_reasm uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_res(cfg_res), .cfg_nch(cfg_nch), .ovr_en(ovr_en), .ovr_res(ovr_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_dac(out_dac), .out_spdif(out_spdif),
    .out_ch(out_ch), .out_odd(out_odd)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int res_bits(input int code);
    return (code == 1) ? 20 : (code == 2) ? 24 : 16;
  endfunction

  // Called at a negedge; returns at the negedge after the word was taken.
  task automatic send(input logic [15:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pair(input int sr_code, input int n, input bit oe, input int or_code,
                          input bit twist, input string tag);
    logic [23:0]  v [16];
    logic [255:0] acc;
    logic [15:0]  words[$];
    int nb, lbits, srb, orb, m, nw;
    exp_t e;
    srb   = res_bits(sr_code);
    lbits = srb - 16;
    orb   = oe ? res_bits(or_code) : srb;
    m     = (orb < srb) ? orb : srb;
    for (int k = 0; k < 2 * n; k++) begin
      v[k]    = 24'($urandom);
      e.dac   = v[k] & (24'hFFFFFF << (24 - m));
      e.spdif = v[k][23:8];
      e.ch    = k % n;
      e.odd   = (k >= n);
      e.tag   = tag;
      sbq.push_back(e);
      words.push_back(v[k][23:8]);
    end
    acc = '0;
    nb  = 0;
    for (int k = 0; k < 2 * n; k++) begin
      if (lbits == 4) acc = (acc << 4) | 256'(v[k][7:4]);
      if (lbits == 8) acc = (acc << 8) | 256'(v[k][7:0]);
      nb += lbits;
    end
    if (nb > 0) begin
      nw  = (nb + 15) / 16;
      acc = acc << (nw * 16 - nb);
      for (int i = 0; i < nw; i++) words.push_back(acc[(nw-1-i)*16 +: 16]);
    end
    cfg_res = 2'(sr_code);
    cfg_nch = 3'(n - 1);
    ovr_en  = oe;
    ovr_res = 2'(or_code);
    foreach (words[i]) begin
      send(words[i]);
      if (i == 0 && twist) begin
        cfg_res = (sr_code == 2) ? 2'd1 : 2'd2;
        cfg_nch = ~cfg_nch;
        ovr_en  = ~oe;
        ovr_res = 2'd0;
      end
    end
    in_valid = 1'b0;
  endtask

  // Sink, scoreboard monitor and flow checks (R8).
  bit          hold_pend = 1'b0;
  logic [23:0] h_dac;
  logic [15:0] h_spdif;
  logic [2:0]  h_ch;
  logic        h_odd;

  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      if (out_valid) begin
        check(!in_ready, "R8", "in_ready while presenting", in_ready, 0);
        if (hold_pend)
          check(out_dac == h_dac && out_spdif == h_spdif && out_ch == h_ch && out_odd == h_odd,
                "R8", "stalled sample changed", out_dac, h_dac);
      end
      hold_pend = 1'b0;
      if (out_valid && !out_ready) begin
        hold_pend = 1'b1;
        h_dac = out_dac; h_spdif = out_spdif; h_ch = out_ch; h_odd = out_odd;
      end
      if (out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R2", "unexpected sample", out_dac, 0);
        end else begin
          e = sbq.pop_front();
          check(out_dac == e.dac, e.tag, "dac sample", out_dac, e.dac);
          check(out_spdif == e.spdif, "R5", "spdif sample", out_spdif, e.spdif);
          check(int'(out_ch) == e.ch && out_odd == e.odd, "R2", "channel/period",
                {out_odd, out_ch}, {e.odd, 3'(e.ch)});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "during reset", {out_valid, in_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset", {out_valid, in_ready}, 2'b01);

    run_pair(0, 8, 0, 0, 0, "R2");          // 16-bit, full width
    run_pair(1, 8, 0, 0, 0, "R3");          // 20-bit, no pad
    run_pair(1, 3, 0, 0, 0, "R3");          // 20-bit, padded word
    run_pair(2, 5, 0, 0, 0, "R4");          // 24-bit
    stall_mode = 1'b1;
    run_pair(2, 8, 0, 0, 0, "R4");
    run_pair(1, 5, 0, 0, 0, "R3");
    run_pair(2, 1, 0, 0, 0, "R10");         // single channel
    run_pair(2, 7, 1, 0, 0, "R6");          // override 16 on 24
    run_pair(2, 4, 1, 1, 0, "R6");          // override 20 on 24
    run_pair(0, 6, 1, 2, 0, "R7");          // override 24 on 16
    run_pair(1, 2, 1, 2, 0, "R7");          // override 24 on 20
    run_pair(1, 3, 0, 0, 1, "R9");          // config twisted after first word
    run_pair(2, 2, 1, 1, 1, "R9");
    run_pair(3, 4, 0, 0, 0, "R10");         // reserved code acts as 16-bit
    stall_mode = 1'b0;
    run_pair(0, 1, 0, 0, 0, "R10");

    for (int t = 0; t < 2000 && sbq.size() != 0; t++) @(negedge clk);
    check(sbq.size() == 0, "R2", "samples outstanding", sbq.size(), 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8", "idle after drain", {out_valid, in_ready}, 2'b01);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule